// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single atomic reservation of one hart and judges each store-conditional the hart issues. A load-reserved event opens a reservation over an aligned granule of memory whose size is set by a parameter, and also records which bytes of the enclosing doubleword the load actually read. A store-conditional asks whether that reservation still stands. The answer comes back one cycle later as a fail flag.

Two kinds of snooped traffic can break the reservation. A store made by another hart breaks it if the store falls anywhere in the reserved granule. A write from a device that is not a hart breaks it only when its byte mask overlaps the exact bytes the load read. A device write to some other part of the granule leaves the reservation standing. Every store-conditional consumes the reservation, whether or not it succeeds, so two store-conditionals can never both pair with one load-reserved.

Top module: `lrsc_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the reservation becomes invalid, and `sc_done` and `sc_fail` become 0.
- R2: A load-reserved event makes `rsv_valid` 1 at the next edge. `rsv_base` then holds the LR address with its low `GRAN_LOG2` bits cleared. `rsv_mask` holds byte i of the doubleword in bit i: 8'hFF for a doubleword, 8'h0F for a word with address bit 2 clear, and 8'hF0 for a word with address bit 2 set. Address bits 1:0 are ignored.
- R3: `sc_done` is 1 for exactly the cycle after each cycle with `sc_valid` high, and `sc_fail` is 0 whenever `sc_done` is 0.
- R4: A store-conditional succeeds (`sc_fail`=0) only if the reservation is still valid after that cycle's snoops and its address lies in the reserved granule. Otherwise it fails (`sc_fail`=1), and this includes an address outside the granule. Access size plays no part in the outcome.
- R5: Every store-conditional, successful or not, leaves `rsv_valid` 0 unless a load-reserved arrives in the same cycle.
- R6: A snooped hart store whose address lies in the reserved granule clears the reservation. A hart store outside the granule leaves it unchanged.
- R7: A snooped device write clears the reservation only when it targets the reserved doubleword and `dev_mask` shares a set bit with `rsv_mask`. Any other device write, including one elsewhere in the granule, leaves the reservation valid.
- R8: Snoops in a cycle take effect before a store-conditional in that cycle, so the store-conditional then fails. Snoops also take effect before a load-reserved in that cycle, so the new reservation stands. A store-conditional and a load-reserved in the same cycle are ordered with the store-conditional first: it is judged on the old reservation, and the load then installs the new one.
- R9: A new load-reserved replaces the previous reservation entirely.
- R10: A store-conditional issued when no load-reserved has occurred since reset fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_valid | input | 1 | Load-reserved event this cycle |
| lr_addr | input | ADDR_W | Load-reserved byte address |
| lr_dw | input | 1 | 1 = doubleword load, 0 = word load |
| sc_valid | input | 1 | Store-conditional request this cycle |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| hst_valid | input | 1 | Snooped store from another hart |
| hst_addr | input | ADDR_W | Address of the snooped hart store |
| dev_valid | input | 1 | Snooped write from a non-hart device |
| dev_addr | input | ADDR_W | Address of the device write (doubleword selected by bits above 2) |
| dev_mask | input | 8 | Bytes written within that doubleword, bit i = byte i |
| sc_done | output | 1 | Result strobe, one cycle after a store-conditional |
| sc_fail | output | 1 | Store-conditional result: 0 success, 1 failure |
| rsv_valid | output | 1 | Reservation currently held |
| rsv_base | output | ADDR_W | Granule-aligned base of the reservation |
| rsv_mask | output | 8 | Bytes read by the load-reserved within its doubleword |

## Verification
The assertions assume that hart stores and device writes each stay inside one naturally aligned doubleword, so a single address identifies the whole access. They also assume a reset at the start and known values on every valid strobe. The stimulus picks every address from a 64-byte window that spans four 16-byte granules, so granule hits, doubleword hits and misses all occur often. Device masks are random bytes, which produces both overlapping and disjoint cases. Snoops, load-reserved and store-conditional events are also made to collide in single cycles, so the ordering rules are exercised.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int DW_BYTES = 8;
  localparam int DW_LSB   = 3;
  typedef logic [DW_BYTES-1:0] bmask_t;
endpackage

// File: rtl/rsv_mask_gen.sv
module rsv_mask_gen
  import lrsc_pkg::*;
(
  input  logic   hi_half,
  input  logic   is_dw,
  output bmask_t mask
);
  for (genvar i = 0; i < DW_BYTES; i++) begin : g_byte
    if (i >= DW_BYTES / 2) begin : g_hi
      assign mask[i] = is_dw | hi_half;
    end else begin : g_lo
      assign mask[i] = is_dw | ~hi_half;
    end
  end
endmodule

// File: rtl/rsv_granule_hit.sv
module rsv_granule_hit #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ADDR_W'((64'd1 << GRAN_LOG2) - 64'd1);
  assign hit = (addr & ~GRAN_MASK) == (base & ~GRAN_MASK);
endmodule

// File: rtl/rsv_dev_hit.sv
module rsv_dev_hit
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] dev_addr,
  input  bmask_t            dev_mask,
  input  logic [ADDR_W-1:0] rsv_addr,
  input  bmask_t            rsv_mask,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] DW_MASK = ADDR_W'(DW_BYTES - 1);
  logic same_dw;
  assign same_dw = (dev_addr & ~DW_MASK) == (rsv_addr & ~DW_MASK);
  assign hit     = same_dw & (|(dev_mask & rsv_mask));
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr_valid,
  input  logic [ADDR_W-1:0] lr_addr,
  input  logic              lr_dw,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              hst_valid,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic              dev_valid,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [7:0]        dev_mask,
  output logic              sc_done,
  output logic              sc_fail,
  output logic              rsv_valid,
  output logic [ADDR_W-1:0] rsv_base,
  output logic [7:0]        rsv_mask
);
  localparam logic [ADDR_W-1:0] DW_MASK   = ADDR_W'(DW_BYTES - 1);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ADDR_W'((64'd1 << GRAN_LOG2) - 64'd1);

  logic [ADDR_W-1:0] rsv_addr_q;
  bmask_t            rsv_mask_q;
  logic              rsv_valid_q;
  bmask_t            lr_mask;
  logic              hst_in_set, sc_in_set, dev_overlap;
  logic              hst_kill, dev_kill, valid_mid, sc_ok;

  rsv_mask_gen u_mask (
    .hi_half (lr_addr[2]),
    .is_dw   (lr_dw),
    .mask    (lr_mask)
  );

  rsv_granule_hit #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_hst_hit (
    .addr (hst_addr),
    .base (rsv_addr_q),
    .hit  (hst_in_set)
  );

  rsv_granule_hit #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_sc_hit (
    .addr (sc_addr),
    .base (rsv_addr_q),
    .hit  (sc_in_set)
  );

  rsv_dev_hit #(.ADDR_W(ADDR_W)) u_dev_hit (
    .dev_addr (dev_addr),
    .dev_mask (dev_mask),
    .rsv_addr (rsv_addr_q),
    .rsv_mask (rsv_mask_q),
    .hit      (dev_overlap)
  );

  // Snoops act first, then the SC, then a same-cycle LR.
  always_comb begin
    hst_kill  = hst_valid & hst_in_set;
    dev_kill  = dev_valid & dev_overlap;
    valid_mid = rsv_valid_q & ~hst_kill & ~dev_kill;
    sc_ok     = sc_valid & valid_mid & sc_in_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsv_valid_q <= 1'b0;
      rsv_addr_q  <= '0;
      rsv_mask_q  <= '0;
      sc_done     <= 1'b0;
      sc_fail     <= 1'b0;
    end else begin
      sc_done <= sc_valid;
      sc_fail <= sc_valid & ~sc_ok;
      if (lr_valid) begin
        rsv_valid_q <= 1'b1;
        rsv_addr_q  <= lr_addr & ~DW_MASK;
        rsv_mask_q  <= lr_mask;
      end else if (sc_valid) begin
        rsv_valid_q <= 1'b0;
      end else begin
        rsv_valid_q <= valid_mid;
      end
    end
  end

  assign rsv_valid = rsv_valid_q;
  assign rsv_base  = rsv_addr_q & ~GRAN_MASK;
  assign rsv_mask  = rsv_mask_q;
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lr_valid,
  input logic              sc_valid,
  input logic [ADDR_W-1:0] sc_addr,
  input logic              hst_valid,
  input logic [ADDR_W-1:0] hst_addr,
  input logic              dev_valid,
  input logic [7:0]        dev_mask,
  input logic              sc_done,
  input logic              sc_fail,
  input logic              rsv_valid,
  input logic [ADDR_W-1:0] rsv_base,
  input logic [7:0]        rsv_mask
);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ADDR_W'((64'd1 << GRAN_LOG2) - 64'd1);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsv_valid && !sc_done && !sc_fail));

  a_r2_lr_opens: assert property (@(posedge clk) disable iff (rst)
    lr_valid |=> rsv_valid);

  a_r3_done_follows: assert property (@(posedge clk) disable iff (rst)
    sc_valid |=> sc_done);

  a_r3_no_stray_done: assert property (@(posedge clk) disable iff (rst)
    !sc_valid |=> !sc_done);

  a_r3_fail_quiet: assert property (@(posedge clk) disable iff (rst)
    !sc_done |-> !sc_fail);

  a_r4_outside_fails: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && ((sc_addr & ~GRAN_MASK) != rsv_base)) |=> sc_fail);

  a_r10_no_rsv_fails: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !rsv_valid) |=> sc_fail);

  a_r5_sc_consumes: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !lr_valid) |=> !rsv_valid);

  a_r6_hart_kills: assert property (@(posedge clk) disable iff (rst)
    (hst_valid && rsv_valid && !lr_valid &&
     ((hst_addr & ~GRAN_MASK) == rsv_base)) |=> !rsv_valid);

  a_r8_snoop_beats_sc: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && hst_valid && ((hst_addr & ~GRAN_MASK) == rsv_base)) |=> sc_fail);

  a_r7_disjoint_keeps: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && rsv_valid && ((dev_mask & rsv_mask) == 8'h00) &&
     !sc_valid && !hst_valid) |=> rsv_valid);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lr_valid  (lr_valid),
  .sc_valid  (sc_valid),
  .sc_addr   (sc_addr),
  .hst_valid (hst_valid),
  .hst_addr  (hst_addr),
  .dev_valid (dev_valid),
  .dev_mask  (dev_mask),
  .sc_done   (sc_done),
  .sc_fail   (sc_fail),
  .rsv_valid (rsv_valid),
  .rsv_base  (rsv_base),
  .rsv_mask  (rsv_mask)
);

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
  localparam int CLK_P     = 10;
  localparam int ADDR_W    = 32;
  localparam int GRAN_LOG2 = 4;
  localparam logic [ADDR_W-1:0] GM = ADDR_W'((64'd1 << GRAN_LOG2) - 64'd1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lr_valid = 1'b0, lr_dw = 1'b0;
  logic [ADDR_W-1:0] lr_addr = '0;
  logic              sc_valid = 1'b0;
  logic [ADDR_W-1:0] sc_addr = '0;
  logic              hst_valid = 1'b0;
  logic [ADDR_W-1:0] hst_addr = '0;
  logic              dev_valid = 1'b0;
  logic [ADDR_W-1:0] dev_addr = '0;
  logic [7:0]        dev_mask = '0;
  logic              sc_done, sc_fail, rsv_valid;
  logic [ADDR_W-1:0] rsv_base;
  logic [7:0]        rsv_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic              m_valid = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [7:0]        m_mask = '0;

  always #(CLK_P/2) clk = ~clk;

  lrsc_monitor #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u0 (
    .clk(clk), .rst(rst),
    .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_dw(lr_dw),
    .sc_valid(sc_valid), .sc_addr(sc_addr),
    .hst_valid(hst_valid), .hst_addr(hst_addr),
    .dev_valid(dev_valid), .dev_addr(dev_addr), .dev_mask(dev_mask),
    .sc_done(sc_done), .sc_fail(sc_fail),
    .rsv_valid(rsv_valid), .rsv_base(rsv_base), .rsv_mask(rsv_mask)
  );

  function automatic logic [ADDR_W-1:0] gran(input logic [ADDR_W-1:0] a);
    return a & ~GM;
  endfunction

  function automatic logic [7:0] lr_bytes(input logic [ADDR_W-1:0] a, input logic dw);
    if (dw) return 8'hFF;
    return a[2] ? 8'hF0 : 8'h0F;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req,
                      input logic lr, input logic [ADDR_W-1:0] lra, input logic lrd,
                      input logic sc, input logic [ADDR_W-1:0] sca,
                      input logic hs, input logic [ADDR_W-1:0] hsa,
                      input logic dv, input logic [ADDR_W-1:0] dva, input logic [7:0] dvm);
    logic hh, dh, vm, ok, exp_fail;
    @(negedge clk);
    lr_valid = lr; lr_addr = lra; lr_dw = lrd;
    sc_valid = sc; sc_addr = sca;
    hst_valid = hs; hst_addr = hsa;
    dev_valid = dv; dev_addr = dva; dev_mask = dvm;
    hh = hs && m_valid && (gran(hsa) == gran(m_addr));
    dh = dv && m_valid && ((dva >> 3) == (m_addr >> 3)) && ((dvm & m_mask) != 8'h00);
    vm = m_valid && !hh && !dh;
    ok = sc && vm && (gran(sca) == gran(m_addr));
    exp_fail = sc && !ok;
    if (lr) begin
      m_valid = 1'b1; m_addr = lra & ~ADDR_W'(7); m_mask = lr_bytes(lra, lrd);
    end else if (sc) begin
      m_valid = 1'b0;
    end else begin
      m_valid = vm;
    end
    @(posedge clk);
    #1;
    check("R3", "sc_done", 64'(sc_done), 64'(sc));
    check(req, "sc_fail", 64'(sc_fail), 64'(exp_fail));
    check(req, "rsv_valid", 64'(rsv_valid), 64'(m_valid));
    if (m_valid) begin
      check(req, "rsv_base", 64'(rsv_base), 64'(gran(m_addr)));
      check(req, "rsv_mask", 64'(rsv_mask), 64'(m_mask));
    end
  endtask

  task automatic idle(input string req);
    step(req, 0, '0, 0, 0, '0, 0, '0, 0, '0, 8'h00);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20191002));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check("R1", "rsv_valid", 64'(rsv_valid), 64'd0);
    check("R1", "sc_done", 64'(sc_done), 64'd0);
    check("R1", "sc_fail", 64'(sc_fail), 64'd0);

    // R10: SC with no prior LR fails
    step("R10", 0, '0, 0, 1, 32'h1000, 0, '0, 0, '0, 8'h00);
    // R2: word LR at upper half, low bits ignored
    step("R2", 1, 32'h1006, 0, 0, '0, 0, '0, 0, '0, 8'h00);
    // R4: SC elsewhere in granule succeeds
    step("R4", 0, '0, 0, 1, 32'h100C, 0, '0, 0, '0, 8'h00);
    // R5: second SC fails
    step("R5", 0, '0, 0, 1, 32'h1004, 0, '0, 0, '0, 8'h00);
    // R4: SC outside granule fails
    step("R2", 1, 32'h1008, 1, 0, '0, 0, '0, 0, '0, 8'h00);
    step("R4", 0, '0, 0, 1, 32'h1010, 0, '0, 0, '0, 8'h00);
    // R6: hart store inside granule kills, outside keeps
    step("R2", 1, 32'h1000, 0, 0, '0, 0, '0, 0, '0, 8'h00);
    step("R6", 0, '0, 0, 0, '0, 1, 32'h100C, 0, '0, 8'h00);
    step("R6", 0, '0, 0, 1, 32'h1000, 0, '0, 0, '0, 8'h00);
    step("R2", 1, 32'h1000, 0, 0, '0, 0, '0, 0, '0, 8'h00);
    step("R6", 0, '0, 0, 0, '0, 1, 32'h1010, 0, '0, 8'h00);
    step("R6", 0, '0, 0, 1, 32'h1000, 0, '0, 0, '0, 8'h00);
    // R7: device writes
    step("R2", 1, 32'h1000, 0, 0, '0, 0, '0, 0, '0, 8'h00);
    step("R7", 0, '0, 0, 0, '0, 0, '0, 1, 32'h1000, 8'hF0);
    step("R7", 0, '0, 0, 0, '0, 0, '0, 1, 32'h1008, 8'hFF);
    step("R7", 0, '0, 0, 0, '0, 0, '0, 1, 32'h1003, 8'h01);
    step("R7", 0, '0, 0, 1, 32'h1000, 0, '0, 0, '0, 8'h00);
    // R8: same-cycle ordering
    step("R2", 1, 32'h1000, 0, 0, '0, 0, '0, 0, '0, 8'h00);
    step("R8", 0, '0, 0, 1, 32'h1000, 1, 32'h1004, 0, '0, 8'h00);
    step("R8", 1, 32'h1000, 1, 0, '0, 0, '0, 1, 32'h1000, 8'hFF);
    step("R8", 1, 32'h1020, 0, 1, 32'h1008, 0, '0, 0, '0, 8'h00);
    step("R8", 0, '0, 0, 1, 32'h1024, 0, '0, 0, '0, 8'h00);
    // R9: newer LR replaces older
    step("R9", 1, 32'h1000, 0, 0, '0, 0, '0, 0, '0, 8'h00);
    step("R9", 1, 32'h2004, 0, 0, '0, 0, '0, 0, '0, 8'h00);
    step("R9", 0, '0, 0, 1, 32'h1000, 0, '0, 0, '0, 8'h00);
    idle("R1");

    for (int i = 0; i < 400; i++) begin
      logic l, s, h, d;
      l = ($urandom % 5) == 0;
      s = ($urandom % 4) == 0;
      h = ($urandom % 7) == 0;
      d = ($urandom % 6) == 0;
      step("R4", l, 32'h1000 + ($urandom % 64), 1'($urandom % 2),
           s, 32'h1000 + ($urandom % 64),
           h, 32'h1000 + ($urandom % 64),
           d, 32'h1000 + ($urandom % 64), 8'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule